// File: doc/BRIEF.md
# CAN Error Flag Sequencer

This block produces the bus level a CAN node drives once one of its fault detectors has found a protocol violation. Five single-cycle inputs report bit, stuff, form, CRC and acknowledgement faults. The first such pulse that arrives while the block is idle starts an error flag at the next bit-time tick. The flag is six bits long. It is dominant when the node is error-active and recessive when the node is error-passive, and the node state is supplied from outside.

After the flag, the block drives recessive and waits for the bus to read back recessive. It then counts out the rest of an eight-bit delimiter, holds a three-bit intermission, and raises a bus-idle output so that the controller may arbitrate again. Every state change happens on a bit-time enable pulse. Error counting and bus-off handling belong to other logic.

Top module: `can_errflag_seq`

## Requirements
- R1: After reset, `tx_level` is 1 (recessive) and `bus_idle` is 1.
- R2: A pulse on any of the five fault inputs while `bus_idle` is 1 starts a flag on the next `bit_tick`. A pulse that arrives between ticks is held until that tick. A pulse that coincides with a tick starts the flag on that same tick.
- R3: For an error-active node (`err_passive` = 0), `tx_level` is 0 (dominant) for exactly 6 bit times, counted from the tick that starts the flag.
- R4: For an error-passive node (`err_passive` = 1), `tx_level` stays 1 during the 6-bit flag, while `bus_idle` is 0.
- R5: The node state is captured when the flag starts. A change of `err_passive` during the flag does not change the flag's level.
- R6: After the flag, the block drives recessive and stays in the waiting state for as long as `rx_level` reads 0 at each tick.
- R7: The first tick that sees `rx_level` = 1 counts as delimiter bit 1. Seven more recessive bit times complete the 8-bit delimiter.
- R8: A 3-bit recessive intermission follows the delimiter. `bus_idle` returns to 1 on the tick that ends it: the 18th tick after flag start when the bus reads recessive throughout.
- R9: Fault pulses that arrive while `bus_idle` is 0 are ignored. No second flag follows the sequence.
- R10: The internal state, and so `tx_level` and `bus_idle`, changes only on a clock edge where `bit_tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle enable at each bit time |
| err_bit | input | 1 | Bit fault pulse |
| err_stuff | input | 1 | Stuff fault pulse |
| err_form | input | 1 | Form fault pulse |
| err_crc | input | 1 | CRC fault pulse |
| err_ack | input | 1 | Acknowledgement fault pulse |
| err_passive | input | 1 | Node state: 1 error-passive, 0 error-active |
| rx_level | input | 1 | Sampled bus level (1 recessive) |
| tx_level | output | 1 | Driven bus level (1 recessive, 0 dominant) |
| bus_idle | output | 1 | 1 when arbitration may resume |

## Verification
The bench walks the whole sequence tick by tick. A flag one bit too short or too long, or a delimiter that counts the first recessive bit twice, shows up as `bus_idle` returning on the wrong tick.

It also:
- holds the bus dominant after the flag, which catches a design that counts the delimiter without waiting;
- flips the node state in the middle of a flag, which catches polarity taken live rather than captured;
- fires faults during the flag and during intermission, where a design that re-arms would start a second flag;
- drives a fault pulse that falls between ticks, which a design that only samples on the tick would lose;
- drives a fault pulse that lands on a tick, which a design that latches first would start one bit late.

// File: rtl/can_errflag_seq.sv
module can_errflag_seq #(
  parameter int FLAG_BITS  = 6,
  parameter int DELIM_BITS = 8,
  parameter int IFS_BITS   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic err_bit,
  input  logic err_stuff,
  input  logic err_form,
  input  logic err_crc,
  input  logic err_ack,
  input  logic err_passive,
  input  logic rx_level,
  output logic tx_level,
  output logic bus_idle
);
  localparam int MAXC = (FLAG_BITS > DELIM_BITS) ?
                        ((FLAG_BITS > IFS_BITS) ? FLAG_BITS : IFS_BITS) :
                        ((DELIM_BITS > IFS_BITS) ? DELIM_BITS : IFS_BITS);
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] FLAG_LAST  = CW'(FLAG_BITS - 1);
  localparam logic [CW-1:0] DELIM_LAST = CW'(DELIM_BITS - 2);
  localparam logic [CW-1:0] IFS_LAST   = CW'(IFS_BITS - 1);

  typedef enum logic [2:0] {S_IDLE, S_FLAG, S_DWAIT, S_DELIM, S_IFS} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          pend;
  logic          flag_rec;

  wire any_err = err_bit | err_stuff | err_form | err_crc | err_ack;
  wire start   = bit_tick & (pend | any_err);

  assign tx_level = (st == S_FLAG) ? flag_rec : 1'b1;
  assign bus_idle = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else if (st != S_IDLE || start) pend <= 1'b0;
    else if (any_err) pend <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      flag_rec <= 1'b1;
    end else if (bit_tick) begin
      unique case (st)
        S_IDLE: if (start) begin
          st       <= S_FLAG;
          cnt      <= '0;
          flag_rec <= err_passive;
        end
        S_FLAG: if (cnt == FLAG_LAST) begin
          st  <= S_DWAIT;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        S_DWAIT: if (rx_level) begin
          st  <= S_DELIM;
          cnt <= '0;
        end
        S_DELIM: if (cnt == DELIM_LAST) begin
          st  <= S_IFS;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        S_IFS: if (cnt == IFS_LAST) begin
          st  <= S_IDLE;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_start_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && bus_idle && any_err) |=> !bus_idle);

  p_flag_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FLAG) |-> (cnt <= FLAG_LAST));

  p_flag_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FLAG && bit_tick && cnt != FLAG_LAST) |=> $stable(tx_level));

  p_wait_dominant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DWAIT && bit_tick && !rx_level) |=> (st == S_DWAIT));

  p_ifs_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IFS && bit_tick && cnt == IFS_LAST) |=> bus_idle);

  p_busy_ignores_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_idle) |=> !pend);

  p_tick_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> ($stable(st) && $stable(cnt)));
endmodule

// File: tb/can_errflag_seq_tb.sv
`timescale 1ns/1ps
module can_errflag_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0;
  logic [4:0] errv = '0;
  logic err_passive = 1'b0;
  logic rx_level = 1'b1;
  logic tx_level, bus_idle;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  can_errflag_seq u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
    .err_bit(errv[0]), .err_stuff(errv[1]), .err_form(errv[2]),
    .err_crc(errv[3]), .err_ack(errv[4]),
    .err_passive(err_passive), .rx_level(rx_level),
    .tx_level(tx_level), .bus_idle(bus_idle)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) bit_tick = 1'b1;
    @(negedge clk) bit_tick = 1'b0;
  endtask

  task automatic pulse(int src);
    @(negedge clk) errv[src] = 1'b1;
    @(negedge clk) errv = '0;
  endtask

  task automatic run_ticks(int from, int upto, logic active);
    for (int k = from; k <= upto; k++) begin
      tick();
      chk(k <= 6 ? "R3" : (k <= 15 ? "R7" : "R8"), "tx_level", tx_level,
          (active && k <= 6) ? 1'b0 : 1'b1);
      chk(k <= 15 ? "R7" : "R8", "bus_idle", bus_idle, k >= 18);
    end
  endtask

  task automatic t_reset();
    chk("R1", "tx_level", tx_level, 1'b1);
    chk("R1", "bus_idle", bus_idle, 1'b1);
  endtask

  task automatic t_sources();
    for (int s = 0; s < 5; s++) begin
      pulse(s);
      repeat (6) @(negedge clk);
      chk("R10", "bus_idle before tick", bus_idle, 1'b1);
      chk("R10", "tx_level before tick", tx_level, 1'b1);
      run_ticks(1, 18, 1'b1);
      chk("R2", "flag completed for source", bus_idle, 1'b1);
    end
  endtask

  task automatic t_passive();
    err_passive = 1'b1;
    pulse(2);
    for (int k = 1; k <= 6; k++) begin
      tick();
      chk("R4", "tx_level passive flag", tx_level, 1'b1);
      chk("R4", "bus_idle passive flag", bus_idle, 1'b0);
    end
    run_ticks(7, 18, 1'b0);
    err_passive = 1'b0;
  endtask

  task automatic t_latch();
    pulse(0);
    tick();
    err_passive = 1'b1;
    for (int k = 2; k <= 6; k++) begin
      tick();
      chk("R5", "active flag after state change", tx_level, 1'b0);
    end
    run_ticks(7, 18, 1'b1);
    err_passive = 1'b1;
    pulse(3);
    tick();
    err_passive = 1'b0;
    for (int k = 2; k <= 6; k++) begin
      tick();
      chk("R5", "passive flag after state change", tx_level, 1'b1);
    end
    run_ticks(7, 18, 1'b0);
    err_passive = 1'b0;
  endtask

  task automatic t_wait();
    pulse(1);
    run_ticks(1, 7, 1'b1);
    rx_level = 1'b0;
    for (int k = 0; k < 5; k++) begin
      tick();
      chk("R6", "tx_level while waiting", tx_level, 1'b1);
      chk("R6", "bus_idle while waiting", bus_idle, 1'b0);
    end
    rx_level = 1'b1;
    for (int k = 1; k <= 11; k++) begin
      tick();
      chk("R7", "bus_idle after release", bus_idle, k == 11);
    end
  endtask

  task automatic t_ignore();
    pulse(4);
    run_ticks(1, 3, 1'b1);
    pulse(0);
    run_ticks(4, 10, 1'b1);
    pulse(3);
    run_ticks(11, 16, 1'b1);
    pulse(2);
    run_ticks(17, 18, 1'b1);
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R9", "no second flag tx", tx_level, 1'b1);
      chk("R9", "no second flag idle", bus_idle, 1'b1);
    end
  endtask

  task automatic t_coincident();
    @(negedge clk) begin
      bit_tick = 1'b1;
      errv[3] = 1'b1;
    end
    @(negedge clk) begin
      bit_tick = 1'b0;
      errv = '0;
    end
    chk("R2", "flag on coincident tick", tx_level, 1'b0);
    chk("R2", "busy on coincident tick", bus_idle, 1'b0);
    run_ticks(2, 18, 1'b1);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sources();
    t_passive();
    t_latch();
    t_wait();
    t_ignore();
    t_coincident();
    summary();
  end
endmodule